// File: doc/BRIEF.md
# Serial Pseudo-SRAM Slave with Single and Quad Lanes

This block is the target side of a serial pseudo-SRAM. It sits behind a chip enable, a serial clock and four bidirectional data lanes. An external master opens a transaction by pulling the chip enable low. It then shifts in an 8-bit opcode and, for memory operations, a 24-bit byte address. After a number of dummy clocks that depends on the opcode and on the current lane mode, bytes stream into or out of an internal byte array.

The block starts in a one-lane mode. Opcodes arrive on lane 0, and read data leaves on lane 1. A mode command switches opcode transfer to all four lanes. Some opcodes move their address and data over four lanes whatever the mode is. A guarded two-step reset command returns the block to one-lane operation. Bursts stay within a 1 KiB page.

The serial clock and the data lanes are sampled with the system clock. Each edge of the serial clock is found by comparing its current value with the value registered on the previous system clock, so the serial clock must stay in each level for at least two system clocks. The array is a synchronous memory with a power-of-two size set by the `MEM_AW` parameter.

Top module: `psram_slave`

## Requirements
- R1: After reset the block is in one-lane mode and drives no lane (`sio_oe` = 0000). Opcode 0x03 in one-lane mode reads with no dummy clocks: 8 opcode bits, then 24 address bits, both MSB first on `sio_in[0]`, then data.
- R2: Opcode 0x0B reads at the current lane width. It inserts 8 dummy clocks in one-lane mode and 4 dummy clocks in four-lane mode.
- R3: Opcode 0xEB reads with its address and data on four lanes in either mode, after 6 dummy clocks.
- R4: In four-lane mode, opcode 0x03 inserts 4 dummy clocks before its data.
- R5: Opcode 0x02 writes at the current lane width, and opcode 0x38 writes with a four-lane address and data. A write has no dummy clocks. Each byte is stored when its last bit is sampled on a rising serial clock edge.
- R6: Opcode 0x35 selects four-lane opcodes only when the block is in one-lane mode. Opcode 0xF5 returns the block to one-lane mode only when it is in four-lane mode. In the other mode each of these opcodes has no effect.
- R7: Opcode 0x99 returns the block to one-lane mode only when the opcode immediately before it was 0x66. Any other opcode between the two cancels the arming.
- R8: After each byte of a burst, the address advances by one within its 1 KiB-aligned page. Offset 0x3FF is followed by offset 0x000 of the same page.
- R9: After an opcode that is not listed here, the block ignores all serial clocks until the chip enable rises. It writes nothing and drives no lane.
- R10: A high chip enable aborts any transaction and returns the block to idle. A write byte that is only partly received is discarded, and the lane mode is kept.
- R11: Read data is driven MSB first, with a change after each falling serial clock edge of the data phase. In one-lane reads only `sio_oe[1]` is set, and in four-lane reads all four enables are set. Outside the data phase of a read, every enable is clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| sclk | input | 1 | Serial clock from the master |
| sio_in | input | 4 | Data lanes as seen at the pins; lane 0 carries one-lane input |
| sio_out | output | 4 | Data the block drives onto the lanes |
| sio_oe | output | 4 | Per-lane output enable |

## Verification
A serial clock edge takes effect at the first system clock edge that samples it. A level driven after a falling edge is therefore valid one system clock later. The bench holds each serial clock level for two system clocks and reads data lanes just before it raises the serial clock. The output enables change one system clock after the serial clock falls or the chip enable rises. The bench's reference model updates its expected enables at the moment it drives that stimulus, and it compares them against the design one time step after every system clock edge. Each byte a read returns is compared with a behavioural byte memory and a lane-mode model. The bench updates both from the opcodes it issues, including the wrap of the burst address and the discarding of aborted bytes.

// File: rtl/psram_pkg.sv
package psram_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CMD,
    PH_ADDR,
    PH_WAIT,
    PH_READ,
    PH_WRITE
  } phase_t;

  localparam logic [7:0] OP_RD_SLOW  = 8'h03;
  localparam logic [7:0] OP_RD_FAST  = 8'h0B;
  localparam logic [7:0] OP_RD_QUAD  = 8'hEB;
  localparam logic [7:0] OP_WR       = 8'h02;
  localparam logic [7:0] OP_WR_QUAD  = 8'h38;
  localparam logic [7:0] OP_LANES4   = 8'h35;
  localparam logic [7:0] OP_LANES1   = 8'hF5;
  localparam logic [7:0] OP_RST_ARM  = 8'h66;
  localparam logic [7:0] OP_RST_GO   = 8'h99;

  typedef struct packed {
    logic       rd;
    logic       wr;
    logic       quad;
    logic [3:0] dummy;
    logic       mode_chg;
    logic       mode_q;
    logic       rst_arm;
  } cmd_dec_t;

endpackage

// File: rtl/psram_decode.sv
module psram_decode
  import psram_pkg::*;
(
  input  logic [7:0] op,
  input  logic       qpi,
  input  logic       armed,
  output cmd_dec_t   dec
);
  always_comb begin
    dec = '0;
    case (op)
      OP_RD_SLOW: begin
        dec.rd    = 1'b1;
        dec.quad  = qpi;
        dec.dummy = qpi ? 4'd4 : 4'd0;
      end
      OP_RD_FAST: begin
        dec.rd    = 1'b1;
        dec.quad  = qpi;
        dec.dummy = qpi ? 4'd4 : 4'd8;
      end
      OP_RD_QUAD: begin
        dec.rd    = 1'b1;
        dec.quad  = 1'b1;
        dec.dummy = 4'd6;
      end
      OP_WR: begin
        dec.wr   = 1'b1;
        dec.quad = qpi;
      end
      OP_WR_QUAD: begin
        dec.wr   = 1'b1;
        dec.quad = 1'b1;
      end
      OP_LANES4: begin
        dec.mode_chg = ~qpi;
        dec.mode_q   = 1'b1;
      end
      OP_LANES1: begin
        dec.mode_chg = qpi;
        dec.mode_q   = 1'b0;
      end
      OP_RST_ARM: dec.rst_arm = 1'b1;
      OP_RST_GO: begin
        dec.mode_chg = armed;
        dec.mode_q   = 1'b0;
      end
      default: dec = '0;
    endcase
  end
endmodule

// File: rtl/psram_mem.sv
module psram_mem #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[addr] <= wdata;
    rdata <= store[addr];
  end
endmodule

// File: rtl/psram_slave.sv
module psram_slave
  import psram_pkg::*;
#(
  parameter int MEM_AW = 11,
  parameter int WRAP_W = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ce_n,
  input  logic       sclk,
  input  logic [3:0] sio_in,
  output logic [3:0] sio_out,
  output logic [3:0] sio_oe
);
  localparam logic [4:0] CMD_BITS  = 5'd8;
  localparam logic [4:0] ADDR_BITS = 5'd24;

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i = rst_sync[1];

  phase_t            phase_q, phase_n;
  logic [4:0]        cnt_q, cnt_n;
  logic [7:0]        sr_q, sr_n;
  logic [MEM_AW-1:0] addr_q, addr_n;
  logic              qpi_q, qpi_n, dquad_q, dquad_n, to_wr_q, to_wr_n;
  logic              armed_q, armed_n, sclk_q, ce_q;
  logic [3:0]        dummy_q, dummy_n, out_q, out_n, oe_q, oe_n;

  logic              rise, fall, ce_start, w4, mem_we;
  logic [4:0]        step, cnt_dec;
  logic [7:0]        sr_in, byte_src, mem_rdata;
  logic [MEM_AW-1:0] addr_in, addr_inc;
  cmd_dec_t          dec;

  assign rise     = sclk & ~sclk_q;
  assign fall     = ~sclk & sclk_q;
  assign ce_start = ~ce_n & ce_q;
  assign w4       = (phase_q == PH_CMD) ? qpi_q : dquad_q;
  assign step     = w4 ? 5'd4 : 5'd1;
  assign cnt_dec  = cnt_q - step;
  assign sr_in    = w4 ? {sr_q[3:0], sio_in} : {sr_q[6:0], sio_in[0]};
  assign addr_in  = w4 ? {addr_q[MEM_AW-5:0], sio_in} : {addr_q[MEM_AW-2:0], sio_in[0]};
  assign addr_inc = {addr_q[MEM_AW-1:WRAP_W], addr_q[WRAP_W-1:0] + 1'b1};
  assign byte_src = (cnt_q == CMD_BITS) ? mem_rdata : sr_q;

  psram_decode u_dec (
    .op    (sr_in),
    .qpi   (qpi_q),
    .armed (armed_q),
    .dec   (dec)
  );

  psram_mem #(.AW(MEM_AW)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .addr  (addr_q),
    .wdata (sr_in),
    .rdata (mem_rdata)
  );

  // next-state logic
  always_comb begin
    phase_n = phase_q;
    cnt_n   = cnt_q;
    sr_n    = sr_q;
    addr_n  = addr_q;
    qpi_n   = qpi_q;
    dquad_n = dquad_q;
    to_wr_n = to_wr_q;
    armed_n = armed_q;
    dummy_n = dummy_q;
    out_n   = out_q;
    oe_n    = oe_q;
    mem_we  = 1'b0;
    if (ce_n) begin
      phase_n = PH_IDLE;
      oe_n    = 4'h0;
    end else begin
      case (phase_q)
        PH_IDLE: if (ce_start) begin
          phase_n = PH_CMD;
          cnt_n   = CMD_BITS;
        end
        PH_CMD: if (rise) begin
          sr_n  = sr_in;
          cnt_n = cnt_dec;
          if (cnt_dec == 5'd0) begin
            armed_n = dec.rst_arm;
            if (dec.mode_chg) qpi_n = dec.mode_q;
            if (dec.rd || dec.wr) begin
              phase_n = PH_ADDR;
              cnt_n   = ADDR_BITS;
              dquad_n = dec.quad;
              dummy_n = dec.dummy;
              to_wr_n = dec.wr;
            end else begin
              phase_n = PH_IDLE;
            end
          end
        end
        PH_ADDR: if (rise) begin
          addr_n = addr_in;
          cnt_n  = cnt_dec;
          if (cnt_dec == 5'd0) begin
            if (dummy_q != 4'd0) begin
              phase_n = PH_WAIT;
              cnt_n   = {1'b0, dummy_q};
            end else begin
              phase_n = to_wr_q ? PH_WRITE : PH_READ;
              cnt_n   = CMD_BITS;
            end
          end
        end
        PH_WAIT: if (rise) begin
          cnt_n = cnt_q - 5'd1;
          if (cnt_q == 5'd1) begin
            phase_n = to_wr_q ? PH_WRITE : PH_READ;
            cnt_n   = CMD_BITS;
          end
        end
        PH_READ: begin
          if (fall) begin
            oe_n = w4 ? 4'hF : 4'h2;
            if (w4) begin
              out_n = byte_src[7:4];
              sr_n  = {byte_src[3:0], 4'h0};
            end else begin
              out_n = {2'b00, byte_src[7], 1'b0};
              sr_n  = {byte_src[6:0], 1'b0};
            end
          end
          if (rise) begin
            cnt_n = cnt_dec;
            if (cnt_dec == 5'd0) begin
              cnt_n  = CMD_BITS;
              addr_n = addr_inc;
            end
          end
        end
        PH_WRITE: if (rise) begin
          sr_n  = sr_in;
          cnt_n = cnt_dec;
          if (cnt_dec == 5'd0) begin
            mem_we = 1'b1;
            cnt_n  = CMD_BITS;
            addr_n = addr_inc;
          end
        end
        default: phase_n = PH_IDLE;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      sr_q    <= '0;
      addr_q  <= '0;
      qpi_q   <= 1'b0;
      dquad_q <= 1'b0;
      to_wr_q <= 1'b0;
      armed_q <= 1'b0;
      dummy_q <= '0;
      out_q   <= '0;
      oe_q    <= '0;
      sclk_q  <= 1'b0;
      ce_q    <= 1'b1;
    end else begin
      phase_q <= phase_n;
      cnt_q   <= cnt_n;
      sr_q    <= sr_n;
      addr_q  <= addr_n;
      qpi_q   <= qpi_n;
      dquad_q <= dquad_n;
      to_wr_q <= to_wr_n;
      armed_q <= armed_n;
      dummy_q <= dummy_n;
      out_q   <= out_n;
      oe_q    <= oe_n;
      sclk_q  <= sclk;
      ce_q    <= ce_n;
    end
  end

  assign sio_out = out_q;
  assign sio_oe  = oe_q;

  // R11: lanes are driven only while a read streams data
  a_r11_oe_only_reading: assert property (@(posedge clk) disable iff (!rst_n)
    (sio_oe != 4'h0) |-> (phase_q == PH_READ));
  // R11: a one-lane read enables lane 1 alone
  a_r11_single_lane: assert property (@(posedge clk) disable iff (!rst_n)
    ((sio_oe != 4'h0) && !dquad_q) |-> (sio_oe == 4'h2));
  // R10: chip enable high forces idle with lanes released
  a_r10_ce_abort: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> (phase_q == PH_IDLE && sio_oe == 4'h0));
  // R6: the lane mode changes only at the end of an opcode
  a_r6_mode_at_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(qpi_q) |-> ($past(phase_q) == PH_CMD));
  // R8: a stored byte never moves the burst out of its page
  a_r8_page_kept: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (addr_q[MEM_AW-1:WRAP_W] == $past(addr_q[MEM_AW-1:WRAP_W])));
  // R2: dummy counter stays within the largest dummy count
  a_r2_wait_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_WAIT) |-> (cnt_q != 5'd0 && cnt_q <= 5'd8));
endmodule

// File: tb/tb_psram_slave.sv
module tb_psram_slave;
  localparam int CLK_PERIOD = 10;
  localparam int H = 2;
  localparam int MEM_AW = 11;

  logic clk, rst_n, ce_n, sclk;
  logic [3:0] sio_in, sio_out, sio_oe;

  psram_slave #(.MEM_AW(MEM_AW), .WRAP_W(10)) dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .sclk(sclk),
    .sio_in(sio_in), .sio_out(sio_out), .sio_oe(sio_oe)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  logic [3:0] exp_oe;
  logic [7:0] model_mem [1 << MEM_AW];
  bit qpi_m, rst_m;
  logic [7:0] wq [$];

  initial begin
    clk = 0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  // per-clock comparison of the lane enables against the model (R11)
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      n_cmp++;
      if (sio_oe !== exp_oe) begin
        n_bad++;
        $display("FAIL R11 lane enable actual=%h expected=%h at %0t", sio_oe, exp_oe, $time);
      end
    end
  end

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic tick(input logic [3:0] din, input logic [3:0] oe_fall, output logic [3:0] dout);
    sclk = 1'b0;
    exp_oe = oe_fall;
    repeat (H) @(negedge clk);
    dout = sio_out;
    sio_in = din;
    sclk = 1'b1;
    repeat (H) @(negedge clk);
  endtask

  task automatic send(input logic [31:0] v, input int nbits, input int w);
    logic [3:0] d;
    for (int k = 0; k < nbits / w; k++) begin
      if (w == 4) tick(v[nbits-1-4*k -: 4], 4'h0, d);
      else        tick({3'b000, v[nbits-1-k]}, 4'h0, d);
    end
  endtask

  function automatic int next_a(input int a);
    return (a & ~32'h3FF) | ((a + 1) & 32'h3FF);
  endfunction

  task automatic xact(input logic [7:0] op, input int a0, input int nb, input int part, input string tag);
    int cw, dw, dum, a;
    bit rd, wr;
    logic [3:0] d;
    logic [7:0] got, b;
    a = a0;
    cw = qpi_m ? 4 : 1;
    dw = cw; dum = 0; rd = 0; wr = 0;
    case (op)
      8'h03: begin rd = 1; dum = qpi_m ? 4 : 0; end
      8'h0B: begin rd = 1; dum = qpi_m ? 4 : 8; end
      8'hEB: begin rd = 1; dw = 4; dum = 6; end
      8'h02: wr = 1;
      8'h38: begin wr = 1; dw = 4; end
      default: ;
    endcase
    ce_n = 1'b0;
    repeat (H) @(negedge clk);
    send({24'h0, op}, 8, cw);
    if (op == 8'h35 && !qpi_m) qpi_m = 1;
    else if (op == 8'hF5 && qpi_m) qpi_m = 0;
    else if (op == 8'h99 && rst_m) qpi_m = 0;
    rst_m = (op == 8'h66);
    if (rd || wr) begin
      send(a, 24, dw);
      for (int k = 0; k < dum; k++) tick(4'h0, 4'h0, d);
    end else if (nb > 0) begin
      send(32'hA5C3_5A3C, 8 * nb, cw);
    end
    if (wr) begin
      for (int i = 0; i < nb; i++) begin
        b = wq.pop_front();
        send({24'h0, b}, 8, dw);
        model_mem[a & ((1 << MEM_AW) - 1)] = b;
        a = next_a(a);
      end
      for (int k = 0; k < part; k++) tick(4'hF, 4'h0, d);
    end
    if (rd) begin
      for (int i = 0; i < nb; i++) begin
        got = '0;
        for (int k = 0; k < 8 / dw; k++) begin
          tick(4'h0, (dw == 4) ? 4'hF : 4'h2, d);
          got = (dw == 4) ? {got[3:0], d} : {got[6:0], d[1]};
        end
        chk(tag, got, model_mem[a & ((1 << MEM_AW) - 1)]);
        a = next_a(a);
      end
    end
    ce_n = 1'b1;
    exp_oe = 4'h0;
    repeat (H) @(negedge clk);
    sclk = 1'b0;
    repeat (H) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    ce_n = 1; sclk = 0; sio_in = 0; rst_n = 0; exp_oe = 0;
    qpi_m = 0; rst_m = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1 reset enables", {4'h0, sio_oe}, 8'h00);

    // R5 one-lane write, R1 plain read
    wq = '{8'hA1, 8'hB2, 8'hC3, 8'hD4};
    xact(8'h02, 32'h010, 4, 0, "R5 one-lane write");
    xact(8'h03, 32'h010, 4, 0, "R1 plain read");
    xact(8'h0B, 32'h011, 2, 0, "R2 fast read one-lane");
    xact(8'hEB, 32'h010, 3, 0, "R3 quad read");
    wq = '{8'h55, 8'hAA};
    xact(8'h38, 32'h100, 2, 0, "R5 quad write");
    xact(8'h03, 32'h100, 2, 0, "R5 quad write readback");
    // R6 exit in one-lane mode is ignored
    xact(8'hF5, 0, 0, 0, "R6");
    xact(8'h03, 32'h012, 1, 0, "R6 exit ignored in one-lane");
    // R6 enter four-lane
    xact(8'h35, 0, 0, 0, "R6");
    xact(8'h03, 32'h010, 2, 0, "R4 plain read four-lane");
    xact(8'h0B, 32'h012, 2, 0, "R2 fast read four-lane");
    wq = '{8'h3C, 8'hE7};
    xact(8'h02, 32'h200, 2, 0, "R5 four-lane write");
    xact(8'h0B, 32'h200, 2, 0, "R5 four-lane write readback");
    xact(8'h35, 0, 0, 0, "R6");
    xact(8'h0B, 32'h100, 2, 0, "R6 enter ignored in four-lane");
    // R7 guarded reset
    xact(8'h99, 0, 0, 0, "R7");
    xact(8'h0B, 32'h010, 1, 0, "R7 unarmed reset ignored");
    xact(8'h66, 0, 0, 0, "R7");
    xact(8'h0B, 32'h011, 1, 0, "R7 read between arm and reset");
    xact(8'h99, 0, 0, 0, "R7");
    xact(8'h0B, 32'h012, 1, 0, "R7 arming cancelled");
    xact(8'h66, 0, 0, 0, "R7");
    xact(8'h99, 0, 0, 0, "R7");
    xact(8'h03, 32'h013, 1, 0, "R7 armed reset returns to one lane");
    // R8 page wrap
    wq = '{8'h01, 8'h02, 8'h03, 8'h04};
    xact(8'h02, 32'h3FE, 4, 0, "R8 wrap write");
    xact(8'h03, 32'h000, 2, 0, "R8 wrap to page start");
    xact(8'hEB, 32'h3FE, 4, 0, "R8 wrap burst read");
    wq = '{8'h9E, 8'h6F};
    xact(8'h02, 32'h7FF, 2, 0, "R8 upper page wrap write");
    xact(8'h03, 32'h400, 1, 0, "R8 upper page start");
    xact(8'h03, 32'h7FF, 2, 0, "R8 upper page burst");
    // R9 unknown opcode ignored
    xact(8'h5A, 0, 4, 0, "R9");
    xact(8'h03, 32'h010, 2, 0, "R9 unknown opcode left memory");
    // R10 abort discards a partial byte, keeps the mode
    wq = '{8'h77};
    xact(8'h02, 32'h301, 1, 0, "R10 setup");
    xact(8'h35, 0, 0, 0, "R6");
    wq = '{8'h11};
    xact(8'h02, 32'h300, 1, 1, "R10 aborted write");
    xact(8'h0B, 32'h300, 2, 0, "R10 partial byte discarded");
    xact(8'hF5, 0, 0, 0, "R6");
    xact(8'h03, 32'h300, 2, 0, "R6 exit from four-lane");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule